// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a parameterised set of level-sensitive peripheral interrupt lines and produces one interrupt request per CPU. The interrupt lines are first brought into the block clock domain through a two-flop synchroniser. Every CPU owns a separate register bank of enable words, so an input is routed to a CPU only by setting its bit in that CPU's enables. An input may be enabled in several banks at once. Each bank also returns status words, which are the synchronised levels masked by that bank's enables. A CPU's output is the registered OR of its status bits and is meant to drive one hardware interrupt pin of that CPU directly.

There is no prioritisation, no vector and no queue. Software reads every status word of its bank to find the pending sources. Enable words are written only as whole words, so software changes them by read-modify-write. The bus is word addressed. Each CPU bank takes an eight-word window, and the windows of consecutive CPUs are adjacent. Within a window, bit 2 of the word address selects status (1) or enable (0), and bits 1:0 select the word. Word n covers inputs 32n to 32n+31.

Top module: `irq_router_top`

## Requirements
- R1: After reset, all enable words read 0, all CPU outputs are 0 and the read data port is 0.
- R2: A write with word address c*8+n (bit 2 clear) loads the full 32-bit enable word n of CPU c, and a later read of that address returns the written value.
- R3: A read of word address c*8+4+n returns the synchronised levels of inputs 32n..32n+31 ANDed with enable word n of CPU c. Bit k of the word corresponds to input 32n+k.
- R4: Writes to status addresses (bit 2 set) change no enable word and no output.
- R5: A change on an input line reaches the status words and the output in fixed time. If an enabled input changes before clock edge k, the CPU output is unchanged after edges k and k+1 and takes the new value after edge k+2.
- R6: When a write captured at edge k clears the last enabled pending bit, the output is still high after edge k and low after edge k+1.
- R7: Each CPU output is driven only by its own bank. A source enabled only in one CPU's bank never raises the other CPU's output.
- R8: A read of a CPU index at or above NUM_CPU, or of a word index at or above NUM_IN/32, returns 0. A write to such an address changes no enable word.
- R9: Read data is registered. It takes the addressed value on the edge that samples the read and holds that value through idle and write cycles until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IN | Level interrupt lines from peripherals (asynchronous) |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | WADDR_W | Word address: [WADDR_W-1:3] CPU, [2] status/enable, [1:0] word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPU | Interrupt request per CPU |

## Verification
An enable write and a new input level can reach the mask on the same clock edge. The bench sets an input line and then times an enable-setting write so that the write is captured on the edge where the synchroniser output rises. The output must still be low right after that edge and high one edge later. Clearing an enable while its input stays high is judged in the same way, edge by edge, and each vector also checks that the other CPU's output and status stay untouched.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned SLOT_W     = 32; // inputs covered by one word
    localparam int unsigned WIN_WORDS  = 8;  // words in one CPU window
    localparam int unsigned WSEL_W     = 2;  // word-select bits in a window
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_s_t;

    sync_s_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 2,
    localparam int unsigned NBITS    = NUM_WORDS * SLOT_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [WSEL_W-1:0]                 wr_word,
    input  logic [SLOT_W-1:0]                 wr_data,
    input  logic [NBITS-1:0]                  lvl_i,
    output logic [NUM_WORDS-1:0][SLOT_W-1:0]  en_o,
    output logic [NUM_WORDS-1:0][SLOT_W-1:0]  stat_o,
    output logic                              irq_o
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][SLOT_W-1:0] en;
        logic                             irq;
    } bank_s_t;

    bank_s_t bank_d, bank_q;
    logic [NBITS-1:0] masked;

    assign masked = lvl_i & bank_q.en;

    always_comb begin
        bank_d = bank_q;
        for (int w = 0; w < int'(NUM_WORDS); w++) begin
            if (wr_en && wr_word == WSEL_W'(w)) bank_d.en[w] = wr_data;
        end
        bank_d.irq = |masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign en_o   = bank_q.en;
    assign stat_o = masked;
    assign irq_o  = bank_q.irq;

    // R2: enables move only on a write to this bank
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q.en));
    // R2: word 0 takes the full written value
    p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word == '0) |=> en_o[0] == $past(wr_data));
    // R5: any pending enabled bit raises the output one edge later
    p_out_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_o) |=> irq_o);
    // R6: nothing pending drops the output one edge later
    p_out_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stat_o) |=> !irq_o);
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_IN  = 64,
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned WADDR_W = 5,
    localparam int unsigned NUM_WORDS = NUM_IN / SLOT_W,
    localparam int unsigned CPU_AW    = WADDR_W - 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   irq_in,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [WADDR_W-1:0]  bus_waddr,
    input  logic [SLOT_W-1:0]   bus_wdata,
    output logic [SLOT_W-1:0]   bus_rdata,
    output logic [NUM_CPU-1:0]  cpu_irq
);
    typedef struct packed {
        logic [SLOT_W-1:0] rdata;
    } top_s_t;

    top_s_t top_d, top_q;

    logic [NUM_IN-1:0]                              lvl_sync;
    logic [NUM_CPU-1:0][NUM_WORDS-1:0][SLOT_W-1:0]  en_all;
    logic [NUM_CPU-1:0][NUM_WORDS-1:0][SLOT_W-1:0]  st_all;
    logic [NUM_CPU-1:0]                             bank_wr;

    logic [CPU_AW-1:0] cpu_sel;
    logic              is_stat;
    logic [WSEL_W-1:0] wsel;

    assign cpu_sel = bus_waddr[WADDR_W-1:3];
    assign is_stat = bus_waddr[2];
    assign wsel    = bus_waddr[WSEL_W-1:0];

    irq_sync #(.WIDTH(NUM_IN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (lvl_sync)
    );

    for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_cpu
        assign bank_wr[c] = bus_sel && bus_wr && !is_stat
                            && (cpu_sel == CPU_AW'(c));
        irq_cpu_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr[c]),
            .wr_word (wsel),
            .wr_data (bus_wdata),
            .lvl_i   (lvl_sync),
            .en_o    (en_all[c]),
            .stat_o  (st_all[c]),
            .irq_o   (cpu_irq[c])
        );
    end

    always_comb begin
        top_d = top_q;
        if (bus_sel && !bus_wr) begin
            top_d.rdata = '0;
            for (int c = 0; c < int'(NUM_CPU); c++) begin
                for (int w = 0; w < int'(NUM_WORDS); w++) begin
                    if (cpu_sel == CPU_AW'(c) && wsel == WSEL_W'(w)) begin
                        top_d.rdata = is_stat ? st_all[c][w] : en_all[c][w];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_rdata = top_q.rdata;

    // R9: read data changes only on a read
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
    // R4: a status-address write leaves every enable word alone
    p_stat_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && is_stat) |=> $stable(en_all));
endmodule

// File: tb/irq_router_top_test.sv
`timescale 1ns/1ps
module irq_router_top_test;
    localparam int NI = 64;
    localparam int NC = 2;
    localparam int AW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NI-1:0]   irq_in = '0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_waddr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   cpu_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_router_top #(.NUM_IN(NI), .NUM_CPU(NC), .WADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    // {irq, en1w1, en1w0, en0w1, en0w0, expected cpu_irq}
    typedef struct packed {
        logic [63:0] irq;
        logic [31:0] e1w1, e1w0, e0w1, e0w0;
        logic [1:0]  out;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{64'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b00},
        '{64'h1, 32'h0, 32'h0, 32'h0, 32'h1, 2'b01},
        '{64'h8000000000000000, 32'h80000000, 32'h0, 32'h0, 32'h0, 2'b10},
        '{64'h0000000100000000, 32'hFFFFFFFE, 32'h0, 32'h0, 32'hFFFFFFFF, 2'b00},
        '{64'hA5A5000000005A5A, 32'h0000FFFF, 32'h0, 32'h0, 32'h000000F0, 2'b01},
        '{64'hFFFFFFFFFFFFFFFF, 32'h0, 32'h2, 32'h10000000, 32'h0, 2'b11}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = AW'(addr);
        @(negedge clk);
        bus_sel = 1'b0;
        data = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] ew [2][2];
        logic [31:0] keep;

        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R1 outputs", 64'(cpu_irq), 64'h0);
        check("R1 rdata", 64'(bus_rdata), 64'h0);
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < 2; w++) begin
                bus_read(c*8 + w, rd);
                check("R1 enable word", 64'(rd), 64'h0);
            end

        // vector table: R2, R3, R7
        for (int i = 0; i < 6; i++) begin
            ew[0][0] = VEC[i].e0w0; ew[0][1] = VEC[i].e0w1;
            ew[1][0] = VEC[i].e1w0; ew[1][1] = VEC[i].e1w1;
            for (int c = 0; c < NC; c++)
                for (int w = 0; w < 2; w++) bus_write(c*8 + w, ew[c][w]);
            @(negedge clk);
            irq_in = VEC[i].irq;
            idle(4);
            check("R7 cpu outputs", 64'(cpu_irq), 64'(VEC[i].out));
            for (int c = 0; c < NC; c++)
                for (int w = 0; w < 2; w++) begin
                    bus_read(c*8 + 4 + w, rd);
                    check("R3 status word", 64'(rd),
                          64'(VEC[i].irq[w*32 +: 32] & ew[c][w]));
                    bus_read(c*8 + w, rd);
                    check("R2 enable readback", 64'(rd), 64'(ew[c][w]));
                end
        end

        // clean state
        irq_in = '0;
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < 2; w++) bus_write(c*8 + w, 32'h0);
        idle(4);

        // R5: input latency, rise and fall
        bus_write(0, 32'h1);
        idle(3);
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk); check("R5 rise after edge 1", 64'(cpu_irq[0]), 64'h0);
        @(negedge clk); check("R5 rise after edge 2", 64'(cpu_irq[0]), 64'h0);
        @(negedge clk); check("R5 rise after edge 3", 64'(cpu_irq[0]), 64'h1);
        @(negedge clk); irq_in[0] = 1'b0;
        @(negedge clk); check("R5 fall after edge 1", 64'(cpu_irq[0]), 64'h1);
        @(negedge clk); check("R5 fall after edge 2", 64'(cpu_irq[0]), 64'h1);
        @(negedge clk); check("R5 fall after edge 3", 64'(cpu_irq[0]), 64'h0);

        // R6: clearing the enable while the input stays high
        irq_in[0] = 1'b1;
        idle(4);
        check("R6 pending before clear", 64'(cpu_irq[0]), 64'h1);
        bus_write(0, 32'h0);
        check("R6 still high after capture edge", 64'(cpu_irq[0]), 64'h1);
        @(negedge clk);
        check("R6 low one edge later", 64'(cpu_irq[0]), 64'h0);
        irq_in[0] = 1'b0;
        idle(4);

        // collision: enable write captured on the edge the synced input rises
        @(negedge clk); irq_in[5] = 1'b1;
        bus_write(0, 32'h20);
        check("R5 collision low after shared edge", 64'(cpu_irq[0]), 64'h0);
        @(negedge clk);
        check("R5 collision high one edge later", 64'(cpu_irq[0]), 64'h1);
        check("R7 collision other cpu", 64'(cpu_irq[1]), 64'h0);

        // R4: writes to status addresses are ignored
        bus_write(4, 32'h0);
        bus_write(12, 32'hFFFFFFFF);
        idle(3);
        bus_read(0, rd);
        check("R4 enable untouched", 64'(rd), 64'h20);
        bus_read(8, rd);
        check("R4 other cpu enable untouched", 64'(rd), 64'h0);
        check("R4 outputs unchanged", 64'(cpu_irq), 64'h1);
        bus_read(4, rd);
        check("R4 status unchanged", 64'(rd), 64'h20);
        irq_in[5] = 1'b0;

        // R8: out-of-range addresses
        bus_write(16, 32'hFFFFFFFF);
        bus_write(2, 32'hFFFFFFFF);
        bus_write(11, 32'hFFFFFFFF);
        bus_read(16, rd);
        check("R8 cpu beyond range reads 0", 64'(rd), 64'h0);
        bus_read(2, rd);
        check("R8 word beyond range reads 0", 64'(rd), 64'h0);
        bus_read(0, rd);
        check("R8 cpu0 w0 untouched", 64'(rd), 64'h20);
        bus_read(1, rd);
        check("R8 cpu0 w1 untouched", 64'(rd), 64'h0);
        bus_read(9, rd);
        check("R8 cpu1 w1 untouched", 64'(rd), 64'h0);

        // R9: registered read data held across idle and write cycles
        bus_write(1, 32'h12345678);
        bus_read(1, rd);
        check("R9 read value", 64'(rd), 64'h12345678);
        keep = bus_rdata;
        bus_write(1, 32'hCAFEF00D);
        idle(2);
        check("R9 held over write and idle", 64'(bus_rdata), 64'(keep));
        bus_read(1, rd);
        check("R9 next read updates", 64'(rd), 64'hCAFEF00D);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule